// File: doc/BRIEF.md
# Programmable Tick Timer

The block is a processor tick timer. It holds a count register and a mode register. Each pulse on the tick enable input, which comes from an external prescaler (nominally 20 MHz, 50 ns per tick), advances the count by one. After every tick the low field of the incremented count is compared with the period field of the mode register.

On a match the block acts according to one of four modes: do nothing, restart the count from zero, stop the count (one-shot), or let it run on and wrap naturally (continuous). When interrupts are enabled, a match also sets a sticky pending flag. The interrupt output is high while both the pending flag and the enable bit are set.

Software uses one write port and one combinational read port, each with a select bit, to reach both registers. Writing the mode register is also how software clears the pending flag.

Top module: `tick_timer`

## Requirements
- R1: After reset the count register reads 0, the mode register reads 0 and `irq` is low.
- R2: A tick with the counter running and no count write adds one to the count, unless a restart match applies. Without a tick, the count holds.
- R3: A match is decided only by the low PERIOD_W bits of the incremented count equalling the period field. Higher count bits play no part.
- R4: In restart mode (mode field 01), a match loads the count with 0.
- R5: In one-shot mode (mode field 10), a match leaves the count at the matched value. The counter then ignores ticks until software writes either register.
- R6: In continuous mode (mode field 11), a match does not disturb counting, and the count wraps from all ones to zero.
- R7: In disabled mode (mode field 00), a match changes neither the count nor the pending flag.
- R8: A match in any mode other than disabled sets the pending flag only when the interrupt-enable bit is 1.
- R9: `irq` equals pending AND interrupt-enable. Pending stays set until software writes the mode register with that bit 0.
- R10: A count write (`wr_sel`=0) loads the value at the next edge, takes priority over a tick in the same cycle, and lets a stopped one-shot counter run again.
- R11: When the period is at or below the current masked count, the next match occurs only after the masked field wraps through zero.
- R12: The mode register is laid out as period in bits [PERIOD_W-1:0], pending at bit PERIOD_W, interrupt enable at bit PERIOD_W+1 and mode at bits [PERIOD_W+3:PERIOD_W+2]. Bits above these read as 0. A mode write replaces all of these fields at the next edge, and the count update in that same cycle follows the previous mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One timer tick per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 count, 1 mode |
| wr_data | input | CNT_W | Write data |
| rd_sel | input | 1 | Read source: 0 count, 1 mode |
| rd_data | output | CNT_W | Read data, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the timer with CNT_W=16 and PERIOD_W=8. With these values the masked field wraps every 256 ticks, so a match that must wait through a wrap is reached within a few hundred cycles. The full count wraps within a single directed step. Random register writes land on all four modes within a short run, and a 16-bit count leaves room above the masked field to show that those upper bits are ignored.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
    typedef enum logic [1:0] {
        TM_OFF     = 2'b00,
        TM_RESTART = 2'b01,
        TM_ONESHOT = 2'b10,
        TM_WRAP    = 2'b11
    } tmode_e;
endpackage

// File: rtl/tt_match.sv
module tt_match #(
    parameter int CNT_W    = 32,
    parameter int PERIOD_W = 28
) (
    input  logic [CNT_W-1:0]    cnt,
    input  logic [PERIOD_W-1:0] period,
    output logic [CNT_W-1:0]    cnt_inc,
    output logic                hit
);
    always_comb begin
        cnt_inc = cnt + 1'b1;
        hit     = (cnt_inc[PERIOD_W-1:0] == period);
    end
endmodule

// File: rtl/tt_counter.sv
module tt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             resume,
    input  logic [CNT_W-1:0] cnt_inc,
    input  logic             zero_hit,
    input  logic             halt_hit,
    output logic [CNT_W-1:0] cnt_o,
    output logic             run_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             halt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt = load_val;
        end else if (tick_en && !st_q.halt) begin
            st_d.cnt = zero_hit ? '0 : cnt_inc;
        end
        if (load || resume) begin
            st_d.halt = 1'b0;
        end else if (halt_hit) begin
            st_d.halt = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
    assign run_o = !st_q.halt;

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !st_q.halt && !load && !zero_hit) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));
    assert_restart_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !st_q.halt && !load && zero_hit) |=> (st_q.cnt == '0));
    assert_oneshot_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.halt && !load && !resume) |=> $stable(st_q.cnt));
    assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (st_q.cnt == $past(load_val)));
endmodule

// File: rtl/tt_modereg.sv
module tt_modereg
    import tick_timer_pkg::*;
#(
    parameter int PERIOD_W = 28
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic [PERIOD_W+3:0]   wr_data,
    input  logic                  hit_ev,
    output logic [PERIOD_W-1:0]   period_o,
    output tmode_e                mode_o,
    output logic                  ie_o,
    output logic                  pend_o,
    output logic [PERIOD_W+3:0]   reg_o
);
    localparam int PEND_BIT = PERIOD_W;
    localparam int IE_BIT   = PERIOD_W + 1;
    localparam int MODE_LO  = PERIOD_W + 2;

    typedef struct packed {
        tmode_e              mode;
        logic                ie;
        logic                pend;
        logic [PERIOD_W-1:0] period;
    } mode_state_t;

    mode_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.period = wr_data[PERIOD_W-1:0];
            st_d.pend   = wr_data[PEND_BIT];
            st_d.ie     = wr_data[IE_BIT];
            st_d.mode   = tmode_e'(wr_data[MODE_LO+1:MODE_LO]);
        end else if (hit_ev && st_q.ie) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign period_o = st_q.period;
    assign mode_o   = st_q.mode;
    assign ie_o     = st_q.ie;
    assign pend_o   = st_q.pend;
    assign reg_o    = st_q;

    assert_pend_needs_ie_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && !st_q.pend && !st_q.ie) |=> !st_q.pend);
    assert_pend_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && st_q.pend) |=> st_q.pend);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int PERIOD_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             rd_sel,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq
);
    localparam int CFG_W = PERIOD_W + 4;

    logic                wr_cnt, wr_mode;
    logic [CNT_W-1:0]    cnt, cnt_inc;
    logic                run, hit, act, hit_ev;
    logic [PERIOD_W-1:0] period;
    tmode_e              mode;
    logic                ie, pend;
    logic [CFG_W-1:0]    mode_reg;

    assign wr_cnt  = wr_en && !wr_sel;
    assign wr_mode = wr_en && wr_sel;

    tt_match #(.CNT_W(CNT_W), .PERIOD_W(PERIOD_W)) u_match (
        .cnt     (cnt),
        .period  (period),
        .cnt_inc (cnt_inc),
        .hit     (hit)
    );

    always_comb begin
        act    = tick_en && run && !wr_cnt;
        hit_ev = act && hit && (mode != TM_OFF);
    end

    tt_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .load     (wr_cnt),
        .load_val (wr_data),
        .resume   (wr_mode),
        .cnt_inc  (cnt_inc),
        .zero_hit (hit_ev && (mode == TM_RESTART)),
        .halt_hit (hit_ev && (mode == TM_ONESHOT)),
        .cnt_o    (cnt),
        .run_o    (run)
    );

    tt_modereg #(.PERIOD_W(PERIOD_W)) u_modereg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (wr_mode),
        .wr_data  (wr_data[CFG_W-1:0]),
        .hit_ev   (hit_ev),
        .period_o (period),
        .mode_o   (mode),
        .ie_o     (ie),
        .pend_o   (pend),
        .reg_o    (mode_reg)
    );

    always_comb begin
        rd_data = '0;
        if (rd_sel) begin
            rd_data[CFG_W-1:0] = mode_reg;
        end else begin
            rd_data = cnt;
        end
    end

    assign irq = pend && ie;

    assert_off_no_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_mode && mode == TM_OFF && !pend) |=> !pend);
    assert_wrap_runs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (act && mode == TM_WRAP) |=> (cnt == $past(cnt) + 1'b1));
    assert_oneshot_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_ev && mode == TM_ONESHOT && !wr_mode) |=> !run);
endmodule

// File: tb/test_tick_timer.sv
module test_tick_timer;
    localparam int CW = 16;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_en = 1'b0, wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
    logic [CW-1:0] wr_data = '0;
    logic [CW-1:0] rd_data;
    logic          irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [CW-1:0] m_cnt;
    logic [PW-1:0] m_per;
    logic          m_pend, m_ie, m_halt;
    logic [1:0]    m_mode;

    tick_timer #(.CNT_W(CW), .PERIOD_W(PW)) i_tick_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
    );

    always #4 clk = ~clk;

    function automatic logic [CW-1:0] exp_mode_reg();
        return {4'b0, m_mode, m_ie, m_pend, m_per};
    endfunction

    task automatic chk(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_step(input logic t, input logic w, input logic s, input logic [CW-1:0] d);
        logic [CW-1:0] inc;
        logic act, hit;
        act = t && !m_halt && !(w && !s);
        inc = m_cnt + 1'b1;
        hit = act && (inc[PW-1:0] == m_per) && (m_mode != 2'b00);
        if (w && !s) begin
            m_cnt = d; m_halt = 1'b0;
        end else if (act) begin
            m_cnt = (hit && m_mode == 2'b01) ? '0 : inc;
        end
        if (w && s) begin
            m_per = d[PW-1:0]; m_pend = d[PW]; m_ie = d[PW+1]; m_mode = d[PW+3:PW+2];
            m_halt = 1'b0;
        end else begin
            if (hit && m_ie) m_pend = 1'b1;
            if (hit && m_mode == 2'b10) m_halt = 1'b1;
        end
    endtask

    task automatic cyc(input logic t, input logic w, input logic s, input logic [CW-1:0] d);
        @(negedge clk);
        tick_en = t; wr_en = w; wr_sel = s; wr_data = d;
        @(posedge clk);
        model_step(t, w, s, d);
        #1;
        tick_en = 1'b0; wr_en = 1'b0;
    endtask

    task automatic verify(input string tc, input string tm, input string ti);
        rd_sel = 1'b0; #1;
        chk(tc, rd_data, m_cnt);
        rd_sel = 1'b1; #1;
        chk(tm, rd_data, exp_mode_reg());
        chk(ti, {15'b0, irq}, {15'b0, m_pend & m_ie});
    endtask

    task automatic wcnt(input logic [CW-1:0] v); cyc(1'b0, 1'b1, 1'b0, v); endtask
    task automatic wmode(input logic [1:0] md, input logic ie, input logic pd, input logic [PW-1:0] p);
        cyc(1'b0, 1'b1, 1'b1, {4'b0, md, ie, pd, p});
    endtask
    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, '0);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_cnt = '0; m_per = '0; m_pend = 1'b0; m_ie = 1'b0; m_halt = 1'b0; m_mode = 2'b00;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        verify("R1 count", "R1 mode", "R1 irq");
        // R2 ticks and idle cycles
        ticks(3);
        verify("R2 count", "R12 mode", "R9 irq");
        cyc(1'b0, 1'b0, 1'b0, '0);
        verify("R2 hold", "R12 mode", "R9 irq");
        // R7 disabled mode match
        wmode(2'b00, 1'b1, 1'b0, 8'd5);
        wcnt(16'd4);
        ticks(1);
        verify("R7 count", "R7 pend", "R7 irq");
        ticks(1);
        verify("R7 count", "R7 pend", "R7 irq");
        // R4 restart, R8 pending with enable
        wmode(2'b01, 1'b1, 1'b0, 8'd4);
        wcnt(16'd0);
        ticks(3);
        verify("R4 count", "R8 mode", "R9 irq");
        ticks(1);
        verify("R4 count", "R8 pend", "R9 irq");
        // R9 sticky pending, then cleared by writing 0
        ticks(2);
        verify("R4 count", "R9 pend", "R9 irq");
        wmode(2'b01, 1'b1, 1'b0, 8'd4);
        verify("R9 count", "R9 clear", "R9 irq");
        wmode(2'b01, 1'b0, 1'b1, 8'd4);
        verify("R9 count", "R12 mode", "R9 irq masked");
        // R3 upper count bits ignored
        wmode(2'b01, 1'b1, 1'b0, 8'd4);
        wcnt(16'h1203);
        ticks(1);
        verify("R3 count", "R3 pend", "R3 irq");
        // R5 one-shot with enable off (R8)
        wmode(2'b10, 1'b0, 1'b0, 8'd6);
        wcnt(16'd4);
        ticks(2);
        verify("R5 count", "R8 nopend", "R8 irq");
        ticks(3);
        verify("R5 hold", "R8 nopend", "R8 irq");
        // R10 count write restarts a stopped counter
        wcnt(16'd10);
        ticks(1);
        verify("R10 resume", "R12 mode", "R9 irq");
        // R10 write wins over simultaneous tick
        cyc(1'b1, 1'b1, 1'b0, 16'h0300);
        verify("R10 load", "R12 mode", "R9 irq");
        // R6 continuous mode
        wmode(2'b11, 1'b1, 1'b0, 8'h10);
        wcnt(16'h000F);
        ticks(1);
        verify("R6 match", "R6 pend", "R6 irq");
        ticks(1);
        verify("R6 run", "R6 pend", "R6 irq");
        wcnt(16'hFFFF);
        ticks(1);
        verify("R6 wrap", "R6 mode", "R6 irq");
        // R11 period below masked count waits for wrap
        wmode(2'b01, 1'b1, 1'b0, 8'd3);
        wcnt(16'd5);
        ticks(253);
        verify("R11 no early", "R11 pend", "R11 irq");
        chk("R11 value", m_cnt, 16'h0102);
        ticks(1);
        verify("R11 match", "R11 pend", "R11 irq");
        chk("R11 zero", m_cnt, 16'h0000);
        // R12 field layout
        cyc(1'b0, 1'b1, 1'b1, 16'hF5A7);
        verify("R12 count", "R12 layout", "R12 irq");
        chk("R12 fixed", exp_mode_reg(), 16'h05A7);
        // random traffic
        for (int n = 0; n < 3000; n++) begin
            logic t, w, s;
            logic [CW-1:0] d;
            t = ($urandom % 4) != 0;
            w = ($urandom % 10) == 0;
            s = $urandom % 2;
            d = CW'($urandom);
            if (w && !s && ($urandom % 2)) d = {8'h00, d[7:0]};
            cyc(t, w, s, d);
            verify("R2 rand count", "R12 rand mode", "R9 rand irq");
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule